// File: doc/BRIEF.md
# Segment RAM Byte Loader

This block sits between a deserialised display-data stream and a 160-column by 4-row segment memory. Every incoming byte is spread over the memory according to the active multiplex setting. In single-backplane operation each bit goes to its own column. With two, three or four backplanes, each column takes a group of two, three or four consecutive bits. A column/row pointer records where the next bit goes. The pointer carries over from one byte to the next, can be reloaded with a new start column, and wraps at the end of the memory.

All eight bit placements of a byte are produced together, one cycle after the byte is presented. Each lane drives its own write enable, column, row and data bit, so the memory can commit a whole byte in one cycle. The loader never stalls and does not wait for any bus handshake. The bit value is passed through unchanged: a 1 turns the element on and a 0 turns it off.

Top module: `segram_loader`

## Requirements
- R1: After reset all lane enables are 0, and the pointer is at column 0, row 0. The first byte after reset therefore starts at column 0, row 0.
- R2: A byte presented with `byte_valid` high in cycle t drives all lane enables high in cycle t+1. In a cycle t+1 that follows a cycle without `byte_valid`, all enables are 0. There is no acknowledge wait.
- R3: Lane k carries byte bit BYTE_W-1-k, so lane 0 is the MSB. The bit is placed first and its value is not changed (1 = on).
- R4: `mode` value m means m+1 rows per column (0 single, 1 two, 2 three, 3 four). Every enabled lane row is below m+1, and bits fill rows in rising order before the column advances.
- R5: With mode 0, a byte written from row 0 lands in row 0 of 8 consecutive columns.
- R6: With mode 1, a byte written from row 0 fills rows 0 and 1 of 4 consecutive columns.
- R7: With mode 3, a byte written from row 0 fills rows 0 to 3 of 2 consecutive columns.
- R8: With mode 2, a bit group of three may straddle bytes. A byte that starts at row 2 places its MSB at row 2 and its next bit at row 0 of the following column.
- R9: Each byte continues from the column and row just after the last bit of the previous byte.
- R10: Column DEPTH-1 (159) is followed by column 0, both inside a byte and across bytes.
- R11: `addr_load` sets the pointer to column `addr_value` and row 0. A byte in the same cycle is placed from that loaded position. A value of DEPTH or more loads column 0.
- R12: A mode change can leave the stored row at or above the new row count. In that case the next byte starts at row 0 of the stored column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_valid | input | 1 | Display byte present this cycle |
| byte_data | input | BYTE_W | Display byte, MSB placed first |
| addr_load | input | 1 | Load start column, row cleared |
| addr_value | input | $clog2(DEPTH) | Start column to load |
| mode | input | 2 | Rows per column minus one |
| wr_en | output | BYTE_W | Per-lane bit write enable |
| wr_col | output | BYTE_W*$clog2(DEPTH) | Lane k column at bits [k*AW +: AW] |
| wr_row | output | BYTE_W*2 | Lane k row at bits [2k +: 2] |
| wr_bit | output | BYTE_W | Per-lane bit value |

## Verification
The bench builds the loader with its default depth of 160 and byte width of 8, so the wrap from column 159 to 0 is real. With an 8-bit column field, values 160 to 255 are legal on the load port, which lets the bench reach the out-of-range load case. Three-row mode does not divide evenly into 8 bits, so runs of three-row bytes reach every starting row and the straddled groups. A random stretch mixes mode switches, loads and idle gaps, and reaches the row-clamp and load-plus-byte cases that directed tests seldom combine.

// File: rtl/segram_pkg.sv
package segram_pkg;
   localparam int ROWS  = 4;
   localparam int ROW_W = $clog2(ROWS);

   typedef enum logic [ROW_W-1:0] {
      MUX_ONE   = 2'd0,
      MUX_TWO   = 2'd1,
      MUX_THREE = 2'd2,
      MUX_FOUR  = 2'd3
   } mux_mode_e;
endpackage

// File: rtl/segram_place.sv
module segram_place #(
   parameter int DEPTH  = 160,
   parameter int OFFSET = 0,
   localparam int AW = $clog2(DEPTH),
   localparam int RW = segram_pkg::ROW_W,
   localparam int PW = $clog2(segram_pkg::ROWS + OFFSET + 1) + 1
) (
   input  logic [AW-1:0] base_col,
   input  logic [RW-1:0] base_row,
   input  logic [RW-1:0] mode,
   output logic [AW-1:0] col,
   output logic [RW-1:0] row
);
   logic [PW-1:0] pos;
   logic [PW-1:0] rows_n;
   logic [PW-1:0] quo;
   logic [AW:0]   sum;

   always_comb begin
      rows_n = PW'(mode) + PW'(1);
      pos    = PW'(base_row) + PW'(OFFSET);
      quo    = pos / rows_n;
      row    = RW'(pos % rows_n);
      sum    = {1'b0, base_col} + (AW+1)'(quo);
      if (sum >= (AW+1)'(DEPTH))
         col = AW'(sum - (AW+1)'(DEPTH));
      else
         col = AW'(sum);
   end
endmodule

// File: rtl/segram_ptr.sv
module segram_ptr #(
   parameter int DEPTH = 160,
   localparam int AW = $clog2(DEPTH),
   localparam int RW = segram_pkg::ROW_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_col,
   input  logic          step,
   input  logic [AW-1:0] next_col,
   input  logic [RW-1:0] next_row,
   output logic [AW-1:0] cur_col,
   output logic [RW-1:0] cur_row
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_col <= '0;
         cur_row <= '0;
      end else if (step) begin
         cur_col <= next_col;
         cur_row <= next_row;
      end else if (load) begin
         cur_col <= load_col;
         cur_row <= '0;
      end
   end
endmodule

// File: rtl/segram_loader.sv
module segram_loader #(
   parameter int DEPTH  = 160,
   parameter int BYTE_W = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int RW = segram_pkg::ROW_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 byte_valid,
   input  logic [BYTE_W-1:0]    byte_data,
   input  logic                 addr_load,
   input  logic [AW-1:0]        addr_value,
   input  logic [RW-1:0]        mode,
   output logic [BYTE_W-1:0]    wr_en,
   output logic [BYTE_W*AW-1:0] wr_col,
   output logic [BYTE_W*RW-1:0] wr_row,
   output logic [BYTE_W-1:0]    wr_bit
);
   generate
      if (BYTE_W < 1)
         $error("segram_loader: BYTE_W must be at least 1");
      if (DEPTH <= BYTE_W + segram_pkg::ROWS)
         $error("segram_loader: DEPTH too small for one byte span");
   endgenerate

   logic [AW-1:0] ptr_col;
   logic [RW-1:0] ptr_row;
   logic [AW-1:0] load_col;
   logic [AW-1:0] base_col;
   logic [RW-1:0] base_row;
   logic [AW-1:0] lane_col [BYTE_W+1];
   logic [RW-1:0] lane_row [BYTE_W+1];

   always_comb begin
      load_col = (addr_value < AW'(DEPTH)) ? addr_value : '0;
      base_col = addr_load ? load_col : ptr_col;
      if (addr_load || (ptr_row > mode))
         base_row = '0;
      else
         base_row = ptr_row;
   end

   generate
      for (genvar k = 0; k <= BYTE_W; k++) begin : g_lane
         segram_place #(.DEPTH(DEPTH), .OFFSET(k)) u_place (
            .base_col (base_col),
            .base_row (base_row),
            .mode     (mode),
            .col      (lane_col[k]),
            .row      (lane_row[k])
         );
      end
   endgenerate

   segram_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (addr_load),
      .load_col (load_col),
      .step     (byte_valid),
      .next_col (lane_col[BYTE_W]),
      .next_row (lane_row[BYTE_W]),
      .cur_col  (ptr_col),
      .cur_row  (ptr_row)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en  <= '0;
         wr_col <= '0;
         wr_row <= '0;
         wr_bit <= '0;
      end else begin
         wr_en <= {BYTE_W{byte_valid}};
         for (int k = 0; k < BYTE_W; k++) begin
            wr_col[k*AW +: AW] <= lane_col[k];
            wr_row[k*RW +: RW] <= lane_row[k];
            wr_bit[k]          <= byte_data[BYTE_W-1-k];
         end
      end
   end
endmodule

// File: rtl/segram_loader_chk.sv
module segram_loader_chk #(
   parameter int DEPTH  = 160,
   parameter int BYTE_W = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int RW = segram_pkg::ROW_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 byte_valid,
   input logic [BYTE_W-1:0]    byte_data,
   input logic                 addr_load,
   input logic [AW-1:0]        addr_value,
   input logic [RW-1:0]        mode,
   input logic [BYTE_W-1:0]    wr_en,
   input logic [BYTE_W*AW-1:0] wr_col,
   input logic [BYTE_W*RW-1:0] wr_row,
   input logic [BYTE_W-1:0]    wr_bit
);
   function automatic logic [BYTE_W-1:0] flip(input logic [BYTE_W-1:0] v);
      logic [BYTE_W-1:0] o;
      for (int i = 0; i < BYTE_W; i++) o[i] = v[BYTE_W-1-i];
      return o;
   endfunction

   function automatic logic [AW-1:0] start_of(input logic [AW-1:0] v);
      return (v < AW'(DEPTH)) ? v : '0;
   endfunction

   p_enable_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> (wr_en == {BYTE_W{1'b1}}));

   p_enable_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_valid |=> (wr_en == '0));

   p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> (wr_bit == flip($past(byte_data))));

   p_load_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_load && byte_valid) |=>
         (wr_col[AW-1:0] == start_of($past(addr_value))) && (wr_row[RW-1:0] == '0));

   generate
      for (genvar k = 0; k < BYTE_W; k++) begin : g_chk
         p_row_in_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[k] |-> (wr_row[k*RW +: RW] <= $past(mode)));

         p_col_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[k] |-> (wr_col[k*AW +: AW] < AW'(DEPTH)));

         if (k > 0) begin : g_step
            p_single_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en[k] && ($past(mode) == '0)) |->
                  (wr_col[k*AW +: AW] ==
                     ((wr_col[(k-1)*AW +: AW] == AW'(DEPTH-1)) ? '0
                                                              : wr_col[(k-1)*AW +: AW] + AW'(1))));
         end
      end
   endgenerate
endmodule

bind segram_loader segram_loader_chk #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .byte_valid (byte_valid),
   .byte_data  (byte_data),
   .addr_load  (addr_load),
   .addr_value (addr_value),
   .mode       (mode),
   .wr_en      (wr_en),
   .wr_col     (wr_col),
   .wr_row     (wr_row),
   .wr_bit     (wr_bit)
);

// File: tb/segram_loader_test.sv
module segram_loader_test;
   localparam int PERIOD = 10;
   localparam int DEPTH  = 160;
   localparam int BYTE_W = 8;
   localparam int AW     = $clog2(DEPTH);
   localparam int RW     = 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 byte_valid = 1'b0;
   logic [BYTE_W-1:0]    byte_data = '0;
   logic                 addr_load = 1'b0;
   logic [AW-1:0]        addr_value = '0;
   logic [RW-1:0]        mode = '0;
   logic [BYTE_W-1:0]    wr_en;
   logic [BYTE_W*AW-1:0] wr_col;
   logic [BYTE_W*RW-1:0] wr_row;
   logic [BYTE_W-1:0]    wr_bit;

   int    errors = 0;
   int    checks = 0;
   string tag = "R1";
   bit    done = 1'b0;

   int mcol = 0, mrow = 0;
   bit exp_en = 1'b0;
   int exp_col [BYTE_W];
   int exp_row [BYTE_W];
   bit exp_bit [BYTE_W];

   always #(PERIOD/2) clk = ~clk;

   segram_loader #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) uut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .addr_load(addr_load), .addr_value(addr_value), .mode(mode),
      .wr_en(wr_en), .wr_col(wr_col), .wr_row(wr_row), .wr_bit(wr_bit));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      int bc, br, r, p;
      if (!rst_n) begin
         exp_en = 1'b0;
         mcol = 0;
         mrow = 0;
      end else begin
         bc = mcol;
         br = mrow;
         r  = int'(mode) + 1;
         if (addr_load) begin
            bc = (int'(addr_value) < DEPTH) ? int'(addr_value) : 0;
            br = 0;
         end
         if (br >= r) br = 0;
         exp_en = byte_valid;
         for (int k = 0; k < BYTE_W; k++) begin
            p = br + k;
            exp_row[k] = p % r;
            exp_col[k] = (bc + p / r) % DEPTH;
            exp_bit[k] = byte_data[BYTE_W-1-k];
         end
         if (byte_valid) begin
            p = br + BYTE_W;
            mcol = (bc + p / r) % DEPTH;
            mrow = p % r;
         end else if (addr_load) begin
            mcol = bc;
            mrow = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(wr_en == {BYTE_W{exp_en}}, tag, "wr_en", int'(wr_en),
               exp_en ? (1 << BYTE_W) - 1 : 0);
         if (exp_en) begin
            for (int k = 0; k < BYTE_W; k++) begin
               check(int'(wr_col[k*AW +: AW]) == exp_col[k], tag, $sformatf("col lane%0d", k),
                     int'(wr_col[k*AW +: AW]), exp_col[k]);
               check(int'(wr_row[k*RW +: RW]) == exp_row[k], tag, $sformatf("row lane%0d", k),
                     int'(wr_row[k*RW +: RW]), exp_row[k]);
               check(wr_bit[k] == exp_bit[k], tag, $sformatf("bit lane%0d", k),
                     int'(wr_bit[k]), int'(exp_bit[k]));
            end
         end
      end
   end

   task automatic send(input logic [BYTE_W-1:0] d);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = d;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic load(input int a);
      @(negedge clk);
      addr_load  = 1'b1;
      addr_value = AW'(a);
      @(negedge clk);
      addr_load  = 1'b0;
   endtask

   function automatic int lcol(input int k);
      return int'(wr_col[k*AW +: AW]);
   endfunction
   function automatic int lrow(input int k);
      return int'(wr_row[k*RW +: RW]);
   endfunction

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(wr_en == '0, "R1", "wr_en in reset", int'(wr_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_en == '0, "R1", "wr_en after reset", int'(wr_en), 0);

      tag = "R5"; mode = 2'd0;
      send(8'hA5);
      check(lcol(0) == 0 && lrow(0) == 0, "R1", "first byte col", lcol(0), 0);
      check(lcol(7) == 7, "R5", "static last col", lcol(7), 7);
      check(wr_bit[0] == 1'b1 && wr_bit[1] == 1'b0, "R3", "msb lane0", int'(wr_bit[1:0]), 1);
      send(8'h3C);
      check(lcol(0) == 8, "R9", "continue col", lcol(0), 8);

      tag = "R6"; mode = 2'd1;
      send(8'hF0);
      check(lcol(7) == 19 && lrow(7) == 1, "R6", "pair last col", lcol(7), 19);
      send(8'h0F);

      tag = "R7"; mode = 2'd3;
      send(8'h96);
      check(lcol(7) == 25 && lrow(7) == 3, "R7", "quad last col", lcol(7), 25);

      tag = "R8"; mode = 2'd2;
      send(8'hFF);
      send(8'h81);
      check(lcol(0) == 28 && lrow(0) == 2, "R8", "straddle start row", lrow(0), 2);
      check(lcol(1) == 29 && lrow(1) == 0, "R8", "straddle next col", lcol(1), 29);
      send(8'h42);

      tag = "R12"; mode = 2'd2;
      load(50);
      send(8'h11);
      mode = 2'd1;
      send(8'h22);
      check(lcol(0) == 52 && lrow(0) == 0, "R12", "clamped row", lrow(0), 0);

      tag = "R10"; mode = 2'd0;
      load(157);
      send(8'hC3);
      check(lcol(3) == 0, "R10", "wrap inside byte", lcol(3), 0);
      check(lcol(2) == 159, "R10", "last column", lcol(2), 159);

      tag = "R11";
      @(negedge clk);
      addr_load = 1'b1; addr_value = AW'(200); byte_valid = 1'b1; byte_data = 8'h5A;
      @(negedge clk);
      addr_load = 1'b0; byte_valid = 1'b0;
      check(lcol(0) == 0 && lrow(0) == 0, "R11", "out of range load", lcol(0), 0);
      @(negedge clk);
      addr_load = 1'b1; addr_value = AW'(90); byte_valid = 1'b1; byte_data = 8'h77; mode = 2'd3;
      @(negedge clk);
      addr_load = 1'b0; byte_valid = 1'b0;
      check(lcol(0) == 90 && lcol(7) == 91, "R11", "load with byte", lcol(7), 91);

      tag = "R2";
      @(negedge clk);
      check(wr_en == '0, "R2", "idle enables", int'(wr_en), 0);

      tag = "R9";
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         byte_valid = ($urandom_range(0, 3) != 0);
         byte_data  = BYTE_W'($urandom);
         addr_load  = ($urandom_range(0, 15) == 0);
         addr_value = AW'($urandom_range(0, 255));
         if ($urandom_range(0, 9) == 0) mode = RW'($urandom_range(0, 3));
      end
      @(negedge clk);
      byte_valid = 1'b0; addr_load = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule